// File: doc/BRIEF.md
# Trimmed One-Second Divider

This block divides a 32.768 kHz oscillator enable down to a one-pulse-per-second tick. It trims the rate in software-set steps by adjusting the divider at its divide-by-256 point. A 5-bit magnitude and a direction bit choose how many minutes of a 64-minute frame get one corrected second. The corrected second is always the first second of each eligible minute.

The trim works in two directions. When the direction bit is 1, the clock runs faster: the corrected second loses 128 oscillator cycles, because the low stage wraps at half count once. When the direction bit is 0, the clock runs slower: the corrected second gains 256 cycles, because the upper stage waits for one extra low-stage wrap.

A halt input freezes the chain. A time-write strobe clears the whole chain and restarts the frame. A 512 Hz square wave, taken from the low stage, is available for frequency measurement. It is gated by two control bits and by the halt input.

Top module: `osc_trim_divider`

## Requirements
- R1: After a synchronous reset, `sec_tick` and `test_wave` are both 0.
- R2: With magnitude 0, every second is exactly 2^(8+POST_BITS) qualified oscillator cycles long (32768 by default).
- R3: With direction 0, a corrected second lasts 256 qualified cycles longer than nominal.
- R4: With direction 1, a corrected second lasts 128 qualified cycles shorter than nominal.
- R5: Second s of minute m is corrected exactly when s = 0, the magnitude N is non-zero and (m mod 64) < 2N. Minutes 62 and 63 are never corrected, and the frame repeats every 64 minutes.
- R6: Only clock cycles with `osc_en` = 1 and `stop_osc` = 0 advance the divider.
- R7: While `stop_osc` is 1, the divider holds its count and `test_wave` is 0.
- R8: `time_wr` clears the divider, the second counter and the minute counter, so the next second is second 0 of minute 0. No tick is issued in the cycle after the clear.
- R9: When `stop_osc` = 0, `out_ctl` = 1 and `ft_ctl` = 1, `test_wave` toggles every 32 qualified cycles (512 Hz), whatever the trim setting. Otherwise it is held at 0.
- R10: `sec_tick` is a single-clock pulse, registered one clock after the last qualified cycle of a second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | One-cycle enable per oscillator period |
| time_wr | input | 1 | Time-write strobe; clears the divider and the frame |
| cal_mag | input | 5 | Trim magnitude N (0 to 31) |
| cal_sign | input | 1 | Trim direction: 1 = faster (-128), 0 = slower (+256) |
| stop_osc | input | 1 | Halts the divider while 1 |
| out_ctl | input | 1 | Output control bit; enables the test wave together with `ft_ctl` |
| ft_ctl | input | 1 | Frequency-test control bit |
| sec_tick | output | 1 | One-clock pulse at the end of each second |
| test_wave | output | 1 | 512 Hz square wave, or 0 when it is gated off |

## Verification
The assertions assume that `cal_mag` and `cal_sign` stay steady within a second. Changing them part-way through a second could leave the upper stage past its normal terminal count without an extension request. The bench therefore changes the trim setting only just before a time-write strobe, and it leaves `time_wr` low throughout each measured second. Each measured interval is counted in qualified enables, not clock cycles. This keeps the expected lengths valid under random enable density and during halt periods.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;

    localparam int PRE_W    = 8;   // divide-by-256 stage
    localparam int MAG_W    = 5;
    localparam int FRAME_W  = 6;   // 64-minute frame
    localparam int WAVE_BIT = 5;   // 32768 / 64 = 512 Hz

    localparam logic [PRE_W-1:0] PRE_FULL = '1;
    localparam logic [PRE_W-1:0] PRE_HALF = PRE_FULL >> 1;

    typedef enum logic [1:0] {
        CORR_NONE = 2'd0,
        CORR_SLOW = 2'd1,
        CORR_FAST = 2'd2
    } corr_e;

    typedef struct packed {
        logic [MAG_W-1:0] mag;
        logic             sign;
    } trim_cfg_t;

    function automatic corr_e pick_corr(trim_cfg_t cfg, logic first_sec,
                                        logic [FRAME_W-1:0] minute);
        logic [FRAME_W-1:0] span;
        span = {cfg.mag, 1'b0};
        if (!first_sec || cfg.mag == '0 || minute >= span)
            return CORR_NONE;
        return cfg.sign ? CORR_FAST : CORR_SLOW;
    endfunction

endpackage

// File: rtl/osc_trim_prescaler.sv
module osc_trim_prescaler
    import osc_trim_pkg::*;
(
    input  logic             clk,
    input  logic             clr,
    input  logic             adv,
    input  logic             half_wrap,
    output logic [PRE_W-1:0] pre_q,
    output logic             carry
);

    logic [PRE_W-1:0] wrap_at;

    always_comb begin
        wrap_at = half_wrap ? PRE_HALF : PRE_FULL;
        carry   = adv && (pre_q == wrap_at);
    end

    always_ff @(posedge clk) begin
        if (clr)
            pre_q <= '0;
        else if (adv)
            pre_q <= carry ? '0 : pre_q + 1'b1;
    end

    // R6: without a qualified enable the low stage does not move
    a_r6_hold_idle: assert property (@(posedge clk) disable iff (clr)
        !adv |=> $stable(pre_q));

endmodule

// File: rtl/osc_trim_sec_stage.sv
module osc_trim_sec_stage #(
    parameter int POST_W = 7
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          carry,
    input  logic          extend,
    output logic [POST_W:0] post_q,
    output logic          sec_end
);

    localparam logic [POST_W:0] LAST_N = {1'b0, {POST_W{1'b1}}};
    localparam logic [POST_W:0] LAST_X = {1'b1, {POST_W{1'b0}}};

    always_comb begin
        sec_end = carry && (post_q == (extend ? LAST_X : LAST_N));
    end

    always_ff @(posedge clk) begin
        if (clr)
            post_q <= '0;
        else if (carry)
            post_q <= sec_end ? '0 : post_q + 1'b1;
    end

    // R3: the extra upper count is reached only under a slow correction
    a_r3_extra_only_slow: assert property (@(posedge clk) disable iff (clr)
        (post_q == LAST_X) |-> extend);

endmodule

// File: rtl/osc_trim_schedule.sv
module osc_trim_schedule
    import osc_trim_pkg::*;
#(
    parameter int SEC_PER_MIN = 60
) (
    input  logic      clk,
    input  logic      clr,
    input  logic      sec_end,
    input  trim_cfg_t cfg,
    output corr_e     corr
);

    localparam int SEC_W = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);

    logic [SEC_W-1:0]   sec_q;
    logic [FRAME_W-1:0] minute_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            sec_q    <= '0;
            minute_q <= '0;
        end else if (sec_end) begin
            if (sec_q == SEC_LAST) begin
                sec_q    <= '0;
                minute_q <= minute_q + 1'b1;
            end else begin
                sec_q <= sec_q + 1'b1;
            end
        end
    end

    always_comb begin
        corr = pick_corr(cfg, sec_q == '0, minute_q);
    end

    // R5: the last two minutes of the frame are never corrected
    a_r5_frame_tail: assert property (@(posedge clk) disable iff (clr)
        (corr != CORR_NONE) |-> (minute_q < FRAME_W'(62)));

    // R5: the minute advances once per completed minute
    a_r5_minute_step: assert property (@(posedge clk) disable iff (clr)
        (sec_end && sec_q == SEC_LAST) |=>
            (minute_q == FRAME_W'($past(minute_q) + 1'b1)));

endmodule

// File: rtl/osc_trim_divider.sv
module osc_trim_divider
    import osc_trim_pkg::*;
#(
    parameter int POST_BITS   = 7,
    parameter int SEC_PER_MIN = 60
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_en,
    input  logic       time_wr,
    input  logic [4:0] cal_mag,
    input  logic       cal_sign,
    input  logic       stop_osc,
    input  logic       out_ctl,
    input  logic       ft_ctl,
    output logic       sec_tick,
    output logic       test_wave
);

    logic             clr;
    logic             adv;
    logic             half_wrap;
    logic             extend;
    logic             carry;
    logic             sec_end;
    logic [PRE_W-1:0] pre_q;
    logic [POST_BITS:0] post_q;
    trim_cfg_t        cfg;
    corr_e            corr;

    always_comb begin
        clr       = rst | time_wr;
        adv       = osc_en & ~stop_osc;
        cfg.mag   = cal_mag;
        cfg.sign  = cal_sign;
        half_wrap = (corr == CORR_FAST) && (post_q == '0);
        extend    = (corr == CORR_SLOW);
        test_wave = out_ctl & ft_ctl & ~stop_osc & pre_q[WAVE_BIT];
    end

    osc_trim_prescaler u_pre (
        .clk       (clk),
        .clr       (clr),
        .adv       (adv),
        .half_wrap (half_wrap),
        .pre_q     (pre_q),
        .carry     (carry)
    );

    osc_trim_sec_stage #(.POST_W(POST_BITS)) u_sec (
        .clk     (clk),
        .clr     (clr),
        .carry   (carry),
        .extend  (extend),
        .post_q  (post_q),
        .sec_end (sec_end)
    );

    osc_trim_schedule #(.SEC_PER_MIN(SEC_PER_MIN)) u_sched (
        .clk     (clk),
        .clr     (clr),
        .sec_end (sec_end),
        .cfg     (cfg),
        .corr    (corr)
    );

    always_ff @(posedge clk) begin
        if (clr)
            sec_tick <= 1'b0;
        else
            sec_tick <= sec_end;
    end

    // R10: the tick never lasts two clocks
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        sec_tick |=> !sec_tick);

    // R8: a time write suppresses the tick that follows it
    a_r8_clear_no_tick: assert property (@(posedge clk) disable iff (rst)
        time_wr |=> !sec_tick);

    // R7: halting freezes both divider stages
    a_r7_stop_freeze: assert property (@(posedge clk) disable iff (clr)
        stop_osc |=> ($stable(pre_q) && $stable(post_q)));

endmodule

// File: tb/osc_trim_divider_tb.sv
module osc_trim_divider_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PB         = 1;
    localparam int SPM        = 2;
    localparam int NOMINAL    = 1 << (8 + PB);
    localparam int WATCHDOG   = 190000;

    logic       clk;
    logic       rst;
    logic       osc_en;
    logic       time_wr;
    logic [4:0] cal_mag;
    logic       cal_sign;
    logic       stop_osc;
    logic       out_ctl;
    logic       ft_ctl;
    logic       sec_tick;
    logic       test_wave;

    int    checks;
    int    errors;
    int    cnt;
    int    k;
    int    density;
    int    cur_mag;
    bit    cur_sign;
    bit    mon;
    bit    done;
    string tag;

    osc_trim_divider #(.POST_BITS(PB), .SEC_PER_MIN(SPM)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .osc_en    (osc_en),
        .time_wr   (time_wr),
        .cal_mag   (cal_mag),
        .cal_sign  (cal_sign),
        .stop_osc  (stop_osc),
        .out_ctl   (out_ctl),
        .ft_ctl    (ft_ctl),
        .sec_tick  (sec_tick),
        .test_wave (test_wave)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int exp_len(int idx, int mag, bit sgn);
        int s;
        int m;
        s = idx % SPM;
        m = (idx / SPM) % 64;
        if (mag != 0 && s == 0 && m < 2 * mag)
            return sgn ? NOMINAL - 128 : NOMINAL + 256;
        return NOMINAL;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    bit last_tick;

    task automatic step();
        int e;
        @(negedge clk);
        if (sec_tick) begin
            // R10: single-clock pulse
            chk(!last_tick, "R10", 1, 0);
            if (mon) begin
                e = exp_len(k, cur_mag, cur_sign);
                chk(cnt == e, tag, cnt, e);
                k++;
            end
            cnt = 0;
        end
        last_tick = sec_tick;
        osc_en = (($urandom % 100) < density) ? 1'b1 : 1'b0;
        if (osc_en && !stop_osc) cnt++;
    endtask

    task automatic set_trim(int mag, bit sgn, int dens);
        cal_mag  = mag[4:0];
        cal_sign = sgn;
        cur_mag  = mag;
        cur_sign = sgn;
        density  = dens;
    endtask

    task automatic resync();
        @(negedge clk);
        time_wr = 1'b1;
        osc_en  = 1'b0;
        @(negedge clk);
        time_wr = 1'b0;
        // R8: no tick right after the clear
        chk(sec_tick == 1'b0, "R8", int'(sec_tick), 0);
        last_tick = sec_tick;
        cnt = 0;
        k   = 0;
        mon = 1'b1;
    endtask

    task automatic run_secs(int n);
        while (k < n) step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", WATCHDOG, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        checks = 0; errors = 0; cnt = 0; k = 0; mon = 1'b0; done = 1'b0;
        last_tick = 1'b0;
        rst = 1'b1; osc_en = 1'b0; time_wr = 1'b0; stop_osc = 1'b0;
        out_ctl = 1'b0; ft_ctl = 1'b0;
        set_trim(0, 1'b0, 100);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(sec_tick == 1'b0, "R1 tick", int'(sec_tick), 0);
        chk(test_wave == 1'b0, "R1 wave", int'(test_wave), 0);
        rst = 1'b0;

        // R2: nominal seconds
        tag = "R2";
        set_trim(0, 1'b0, 100);
        resync();
        run_secs(6);

        // R6: sparse enables
        tag = "R6";
        set_trim(0, 1'b0, 40);
        resync();
        run_secs(4);

        // R3: slow correction
        tag = "R3 R5";
        set_trim(3, 1'b0, 100);
        resync();
        run_secs(16);

        // R4: fast correction with gaps in the enable
        tag = "R4 R5";
        set_trim(5, 1'b1, 70);
        resync();
        run_secs(24);

        // R5: full frame at maximum magnitude, then the wrap
        tag = "R5 frame";
        set_trim(31, 1'b1, 100);
        resync();
        run_secs(132);

        // R8: clear part-way through a frame restarts it
        tag = "R8 restart";
        set_trim(2, 1'b0, 100);
        resync();
        run_secs(5);
        repeat (100) step();
        resync();
        run_secs(3);

        // R7: halt freezes the count and gates the wave
        tag = "R7";
        set_trim(0, 1'b0, 100);
        out_ctl = 1'b1;
        ft_ctl  = 1'b1;
        resync();
        repeat (100) step();
        stop_osc = 1'b1;
        begin
            int high_seen;
            high_seen = 0;
            for (int i = 0; i < 150; i++) begin
                step();
                if (test_wave) high_seen++;
            end
            chk(high_seen == 0, "R7 wave", high_seen, 0);
        end
        stop_osc = 1'b0;
        run_secs(2);

        // R9: wave period under an active fast correction
        tag = "R9 R4";
        set_trim(31, 1'b1, 100);
        resync();
        begin
            int  run;
            int  seen;
            bit  prev;
            run = 0; seen = 0; prev = test_wave;
            for (int i = 0; i < 800 && seen < 12; i++) begin
                step();
                run++;
                if (test_wave != prev) begin
                    if (seen > 0) chk(run == 32, "R9 period", run, 32);
                    seen++;
                    run  = 0;
                    prev = test_wave;
                end
            end
            chk(seen >= 12, "R9 toggles", seen, 12);
        end
        // R9: gated off by the frequency-test bit
        ft_ctl = 1'b0;
        begin
            int high_seen;
            high_seen = 0;
            for (int i = 0; i < 200; i++) begin
                step();
                if (test_wave) high_seen++;
            end
            chk(high_seen == 0, "R9 gated", high_seen, 0);
        end
        out_ctl = 1'b0;

        // R5: random settings
        tag = "R5 random";
        for (int r = 0; r < 3; r++) begin
            set_trim(int'($urandom % 32), bit'($urandom % 2),
                     30 + int'($urandom % 71));
            resync();
            run_secs(8);
        end

        finish_run();
    end

endmodule